// File: doc/BRIEF.md
# Host-Cleared Interrupt Request Register

This block gathers interrupt requests raised by user logic on four lines and keeps each one as a sticky pending bit. The pending bits drive level interrupt requests toward a PCIe DMA engine's user-interrupt port. They stay raised until the host driver has serviced the event and cleared the bit through a register write. The engine's per-line acknowledge does not change the pending state. Clearing is always the host's explicit decision.

Register access uses an AXI4-Lite slave. A read-only status word shows the pending lines. A write-1-to-clear word drops the serviced lines. The write address and write data channels can arrive in either order. Every transaction answers OKAY. Unmapped reads return zero. Writes to the status word or to unmapped offsets do nothing.

Top module: `irq_sticky_regs`

## Requirements
- R1: After the active-low synchronous reset (`rst_n` low on a clock edge), all pending bits and `irq_req_o` are 0, `s_bvalid` and `s_rvalid` are 0, and `s_awready`, `s_wready` and `s_arready` are 1.
- R2: If `usr_req_i[n]` is 1 at a clock edge, pending bit n is 1 after that edge, and `irq_req_o[n]` is 1 from that edge on.
- R3: A read of offset 0x0 returns the pending bits in `s_rdata[3:0]` with bit n for line n, zero in every higher bit, and `s_rresp` = 2'b00. The read data reflects the pending bits at the address handshake edge, and `s_rvalid` rises on that same edge.
- R4: A write to offset 0x4 with `s_wstrb[0]` = 1 clears pending bit n for each n where `s_wdata[n]` = 1, and leaves the bits where `s_wdata[n]` = 0 unchanged. The clear takes effect on the edge after both channels have been captured.
- R5: If a request on line n and a host clear of line n fall on the same edge, pending bit n stays 1.
- R6: `irq_ack_i` has no effect on the pending bits. `irq_req_o[n]` stays 1 while `irq_ack_i[n]` is asserted, until the host clears line n.
- R7: The write address and write data channels are accepted in any order or together. `s_bvalid` stays 0 until both are captured, and the response is `s_bresp` = 2'b00.
- R8: Reads of any offset other than 0x0 return 0. Writes to 0x0 or to any offset other than 0x4 leave the pending bits unchanged.
- R9: A write to 0x4 with `s_wstrb[0]` = 0 clears nothing.
- R10: A pending bit stays 1 after its request input returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| usr_req_i | input | 4 | Interrupt requests from user logic, one per line |
| irq_req_o | output | 4 | Level interrupt requests to the DMA engine |
| irq_ack_i | input | 4 | Per-line acknowledge from the DMA engine (no effect on state) |
| s_awaddr | input | 4 | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | 4 | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |

## Verification
A new request from user logic and a host clear can hit the same pending bit on the same edge. The bench provokes this by raising the request for a line exactly in the commit cycle of a clear write that names the same line, together with another line that has no new request. It judges the result from a following status read and from `irq_req_o`. The colliding line must still be pending, and the other cleared line must be gone.

// File: rtl/irq_regs_pkg.sv
// Package: shared register offsets and response codes for the sticky
// interrupt register block. Assumes 32-bit word-aligned register slots.
package irq_regs_pkg;
    localparam int STAT_WORD = 0;   // offset 0x0, read-only pending status
    localparam int CLR_WORD  = 1;   // offset 0x4, write-1-to-clear

    typedef enum logic [1:0] {
        RESP_OKAY   = 2'b00,
        RESP_EXOKAY = 2'b01,
        RESP_SLVERR = 2'b10,
        RESP_DECERR = 2'b11
    } axi_resp_e;
endpackage

// File: rtl/irq_axil_wr.sv
// Write side of the AXI4-Lite slave. Captures address and data in any
// order, then commits once: it emits a one-cycle clear vector and raises
// the OKAY response. Assumes the word index sits in addr[ADDR_W-1:2].
module irq_axil_wr #(
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 32,
    parameter int NUM_LINES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    awaddr,
    input  logic                 awvalid,
    output logic                 awready,
    input  logic [DATA_W-1:0]    wdata,
    input  logic [DATA_W/8-1:0]  wstrb,
    input  logic                 wvalid,
    output logic                 wready,
    output logic [1:0]           bresp,
    output logic                 bvalid,
    input  logic                 bready,
    output logic [NUM_LINES-1:0] clr_vec
);
    import irq_regs_pkg::*;

    localparam int IDX_W = ADDR_W - 2;

    logic                 aw_got;
    logic                 w_got;
    logic [IDX_W-1:0]     aw_idx;
    logic [NUM_LINES-1:0] w_bits;
    logic                 w_strb0;
    logic                 commit;
    logic                 unused_wr;

    assign unused_wr = ^{awaddr[1:0], wdata, wstrb};

    assign awready = !aw_got;
    assign wready  = !w_got;
    assign commit  = aw_got && w_got && !bvalid;
    assign bresp   = RESP_OKAY;

    // Address channel capture; released on commit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aw_got <= 1'b0;
            aw_idx <= '0;
        end else if (awvalid && awready) begin
            aw_got <= 1'b1;
            aw_idx <= awaddr[ADDR_W-1:2];
        end else if (commit) begin
            aw_got <= 1'b0;
        end
    end

    // Data channel capture; only the low strobe lane and line bits matter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_got   <= 1'b0;
            w_bits  <= '0;
            w_strb0 <= 1'b0;
        end else if (wvalid && wready) begin
            w_got   <= 1'b1;
            w_bits  <= wdata[NUM_LINES-1:0];
            w_strb0 <= wstrb[0];
        end else if (commit) begin
            w_got <= 1'b0;
        end
    end

    // Response handshake: raised on commit, dropped when accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bvalid <= 1'b0;
        end else if (commit) begin
            bvalid <= 1'b1;
        end else if (bready) begin
            bvalid <= 1'b0;
        end
    end

    // Clear vector decode: only the clear word with lane 0 enabled acts.
    always_comb begin
        clr_vec = '0;
        if (commit && (int'(aw_idx) == CLR_WORD) && w_strb0) begin
            clr_vec = w_bits;
        end
    end

    // R7: a response only appears after both channels were held.
    a_r7_b_after_both: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bvalid) |-> $past(aw_got && w_got));

    // R7: a pending response is held until accepted.
    a_r7_b_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bvalid && !bready) |=> bvalid);
endmodule

// File: rtl/irq_axil_rd.sv
// Read side of the AXI4-Lite slave. One outstanding read: the address is
// accepted when no data is waiting, and the data is registered from the
// pending bits at the handshake edge. Unmapped offsets read as zero.
module irq_axil_rd #(
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 32,
    parameter int NUM_LINES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    araddr,
    input  logic                 arvalid,
    output logic                 arready,
    output logic [DATA_W-1:0]    rdata,
    output logic [1:0]           rresp,
    output logic                 rvalid,
    input  logic                 rready,
    input  logic [NUM_LINES-1:0] pending
);
    import irq_regs_pkg::*;

    logic              ar_hs;
    logic [DATA_W-1:0] rd_word;
    logic              unused_rd;

    assign unused_rd = ^araddr[1:0];
    assign arready   = !rvalid;
    assign ar_hs     = arvalid && arready;
    assign rresp     = RESP_OKAY;

    // Read mux: status word carries the pending bits, all else is zero.
    always_comb begin
        rd_word = '0;
        if (int'(araddr[ADDR_W-1:2]) == STAT_WORD) begin
            rd_word[NUM_LINES-1:0] = pending;
        end
    end

    // Read data register and valid handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else if (ar_hs) begin
            rvalid <= 1'b1;
            rdata  <= rd_word;
        end else if (rready) begin
            rvalid <= 1'b0;
        end
    end

    // R3: read data is held steady while waiting for the master.
    a_r3_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rvalid && !rready) |=> (rvalid && $stable(rdata)));

    // R8: an unmapped read produces zero data.
    a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (ar_hs && (int'(araddr[ADDR_W-1:2]) != STAT_WORD)) |=> (rdata == '0));
endmodule

// File: rtl/irq_pend_bank.sv
// Bank of sticky pending bits, one per interrupt line. A request sets its
// bit, a host clear drops it, and a request wins a same-edge collision.
// The engine acknowledge is observed only by the checks here.
module irq_pend_bank #(
    parameter int NUM_LINES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] req,
    input  logic [NUM_LINES-1:0] clr,
    input  logic [NUM_LINES-1:0] ack,
    output logic [NUM_LINES-1:0] pending
);
    logic unused_ack;
    assign unused_ack = ^ack;

    for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
        // Per-line sticky flop: set has priority over clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pending[n] <= 1'b0;
            end else if (req[n]) begin
                pending[n] <= 1'b1;
            end else if (clr[n]) begin
                pending[n] <= 1'b0;
            end
        end

        // R2: a request is pending after its edge.
        a_r2_set: assert property (@(posedge clk) disable iff (!rst_n)
            req[n] |=> pending[n]);

        // R5: a collision of set and clear keeps the line pending.
        a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            (req[n] && clr[n]) |=> pending[n]);

        // R6: acknowledge never drops a pending line.
        a_r6_ack_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
            (ack[n] && pending[n] && !clr[n]) |=> pending[n]);

        // R10: without a clear a pending line stays set.
        a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (pending[n] && !clr[n]) |=> pending[n]);
    end
endmodule

// File: rtl/irq_sticky_regs.sv
// Top of the host-cleared interrupt register block: user requests land in
// sticky pending bits, which drive level requests to a DMA engine. The host
// reads status at 0x0 and clears with write-1 at 0x4 over AXI4-Lite.
module irq_sticky_regs #(
    parameter int NUM_LINES = 4,
    parameter int ADDR_W    = 4,
    parameter int DATA_W    = 32,
    localparam int STRB_W   = DATA_W / 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] usr_req_i,
    output logic [NUM_LINES-1:0] irq_req_o,
    input  logic [NUM_LINES-1:0] irq_ack_i,
    input  logic [ADDR_W-1:0]    s_awaddr,
    input  logic                 s_awvalid,
    output logic                 s_awready,
    input  logic [DATA_W-1:0]    s_wdata,
    input  logic [STRB_W-1:0]    s_wstrb,
    input  logic                 s_wvalid,
    output logic                 s_wready,
    output logic [1:0]           s_bresp,
    output logic                 s_bvalid,
    input  logic                 s_bready,
    input  logic [ADDR_W-1:0]    s_araddr,
    input  logic                 s_arvalid,
    output logic                 s_arready,
    output logic [DATA_W-1:0]    s_rdata,
    output logic [1:0]           s_rresp,
    output logic                 s_rvalid,
    input  logic                 s_rready
);
    logic [NUM_LINES-1:0] clr_vec;
    logic [NUM_LINES-1:0] pending;

    irq_axil_wr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_LINES(NUM_LINES)) u_wr (
        .clk     (clk),
        .rst_n   (rst_n),
        .awaddr  (s_awaddr),
        .awvalid (s_awvalid),
        .awready (s_awready),
        .wdata   (s_wdata),
        .wstrb   (s_wstrb),
        .wvalid  (s_wvalid),
        .wready  (s_wready),
        .bresp   (s_bresp),
        .bvalid  (s_bvalid),
        .bready  (s_bready),
        .clr_vec (clr_vec)
    );

    irq_pend_bank #(.NUM_LINES(NUM_LINES)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (usr_req_i),
        .clr     (clr_vec),
        .ack     (irq_ack_i),
        .pending (pending)
    );

    irq_axil_rd #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_LINES(NUM_LINES)) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .araddr  (s_araddr),
        .arvalid (s_arvalid),
        .arready (s_arready),
        .rdata   (s_rdata),
        .rresp   (s_rresp),
        .rvalid  (s_rvalid),
        .rready  (s_rready),
        .pending (pending)
    );

    assign irq_req_o = pending;

    // R4: a clear vector with no competing request drops the line.
    a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_vec[0] && !usr_req_i[0]) |=> !irq_req_o[0]);

    // R1: handshake outputs idle after reset.
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (!s_bvalid && !s_rvalid && irq_req_o == '0));
endmodule

// File: tb/test_irq_sticky_regs.sv
// Scoreboard bench: driver tasks push expected reads and responses, and a
// monitor at the falling edge pops and compares them.
module test_irq_sticky_regs;
    localparam int CLK_NS = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  usr_req_i = '0;
    logic [3:0]  irq_req_o;
    logic [3:0]  irq_ack_i = '0;
    logic [3:0]  s_awaddr = '0;
    logic        s_awvalid = 1'b0;
    logic        s_awready;
    logic [31:0] s_wdata = '0;
    logic [3:0]  s_wstrb = '0;
    logic        s_wvalid = 1'b0;
    logic        s_wready;
    logic [1:0]  s_bresp;
    logic        s_bvalid;
    logic        s_bready = 1'b1;
    logic [3:0]  s_araddr = '0;
    logic        s_arvalid = 1'b0;
    logic        s_arready;
    logic [31:0] s_rdata;
    logic [1:0]  s_rresp;
    logic        s_rvalid;
    logic        s_rready = 1'b1;

    int          n_tests = 0;
    int          n_fail  = 0;
    int          b_pend  = 0;
    logic [31:0] rd_q[$];
    string       tag_q[$];

    irq_sticky_regs i_irq_sticky_regs (.*);

    always #(CLK_NS/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // Monitor: compare read data and write responses against the queues.
    always @(negedge clk) begin
        if (rst_n) begin
            if (s_bvalid) begin
                chk(s_bresp == 2'b00, "R7 bresp", 32'(s_bresp), 0);
                chk(b_pend > 0, "R7 unexpected bvalid", 32'(b_pend), 1);
                if (b_pend > 0) b_pend--;
            end
            if (s_rvalid) begin
                if (rd_q.size() == 0) begin
                    chk(1'b0, "R3 unexpected rvalid", s_rdata, 0);
                end else begin
                    logic [31:0] e;
                    string t;
                    e = rd_q.pop_front();
                    t = tag_q.pop_front();
                    chk(s_rdata == e, t, s_rdata, e);
                    chk(s_rresp == 2'b00, "R3 rresp", 32'(s_rresp), 0);
                end
            end
        end
    end

    task automatic axi_read(input logic [3:0] a, input logic [31:0] exp, input string tag);
        rd_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        s_araddr  = a;
        s_arvalid = 1'b1;
        while (!s_arready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        s_arvalid = 1'b0;
        while (rd_q.size() > 0) @(negedge clk);
    endtask

    // order: 0 together, 1 address first, 2 data first; gap idle cycles
    // between channels; coll is driven on usr_req_i in the commit cycle.
    task automatic axi_write(input logic [3:0] a, input logic [31:0] d, input logic [3:0] s,
                             input int order, input int gap, input logic [3:0] coll);
        b_pend++;
        @(negedge clk);
        if (order == 0) begin
            s_awaddr = a; s_awvalid = 1'b1;
            s_wdata = d; s_wstrb = s; s_wvalid = 1'b1;
            while (!(s_awready && s_wready)) @(negedge clk);
            @(posedge clk);
            @(negedge clk);
            s_awvalid = 1'b0; s_wvalid = 1'b0;
            usr_req_i = coll;
            @(negedge clk);
            usr_req_i = '0;
        end else begin
            if (order == 1) begin s_awaddr = a; s_awvalid = 1'b1; end
            else begin s_wdata = d; s_wstrb = s; s_wvalid = 1'b1; end
            @(posedge clk);
            @(negedge clk);
            s_awvalid = 1'b0; s_wvalid = 1'b0;
            for (int i = 0; i < gap; i++) begin
                chk(!s_bvalid, "R7 bvalid before both channels", 32'(s_bvalid), 0);
                @(negedge clk);
            end
            if (order == 1) begin s_wdata = d; s_wstrb = s; s_wvalid = 1'b1; end
            else begin s_awaddr = a; s_awvalid = 1'b1; end
            @(posedge clk);
            @(negedge clk);
            s_awvalid = 1'b0; s_wvalid = 1'b0;
        end
        while (b_pend > 0) @(negedge clk);
    endtask

    task automatic pulse(input logic [3:0] m);
        @(negedge clk);
        usr_req_i = m;
        @(negedge clk);
        usr_req_i = '0;
    endtask

    initial begin
        #(CLK_NS * 100000);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk(irq_req_o == 4'h0, "R1 irq_req_o", 32'(irq_req_o), 0);
        chk({s_bvalid, s_rvalid} == 2'b00, "R1 valids", 32'({s_bvalid, s_rvalid}), 0);
        chk({s_awready, s_wready, s_arready} == 3'b111, "R1 readies",
            32'({s_awready, s_wready, s_arready}), 7);
        axi_read(4'h0, 32'h0, "R1 status after reset");

        // R2 / R10: set and stickiness
        pulse(4'b0001);
        chk(irq_req_o == 4'b0001, "R2 irq_req_o after pulse", 32'(irq_req_o), 1);
        repeat (3) @(negedge clk);
        chk(irq_req_o == 4'b0001, "R10 sticky after request drop", 32'(irq_req_o), 1);
        axi_read(4'h0, 32'h1, "R3 status one line");
        pulse(4'b1010);
        axi_read(4'h0, 32'hB, "R3 status three lines");

        // R6: acknowledge changes nothing
        @(negedge clk);
        irq_ack_i = 4'hF;
        repeat (3) @(negedge clk);
        chk(irq_req_o == 4'hB, "R6 irq_req_o during ack", 32'(irq_req_o), 32'hB);
        irq_ack_i = 4'h0;
        axi_read(4'h0, 32'hB, "R6 status after ack");

        // R4: write-1-to-clear, both channels together
        axi_write(4'h4, 32'h2, 4'hF, 0, 0, 4'h0);
        axi_read(4'h0, 32'h9, "R4 clear line 1");
        chk(irq_req_o == 4'h9, "R4 irq_req_o after clear", 32'(irq_req_o), 9);

        // R8: writes to status and unmapped offsets ignored; unmapped reads zero
        axi_write(4'h0, 32'hF, 4'hF, 1, 2, 4'h0);
        axi_read(4'h0, 32'h9, "R8 write to status ignored");
        axi_write(4'h8, 32'hF, 4'hF, 2, 2, 4'h0);
        axi_read(4'h0, 32'h9, "R8 write to unmapped ignored");
        axi_read(4'h8, 32'h0, "R8 unmapped read 0x8");
        axi_read(4'hC, 32'h0, "R8 unmapped read 0xC");
        axi_read(4'h4, 32'h0, "R8 clear word reads zero");

        // R9: strobe lane 0 off clears nothing
        axi_write(4'h4, 32'hF, 4'hE, 0, 0, 4'h0);
        axi_read(4'h0, 32'h9, "R9 no strobe no clear");

        // R7: data first with a long gap, then clears line 0
        axi_write(4'h4, 32'h1, 4'h1, 2, 5, 4'h0);
        axi_read(4'h0, 32'h8, "R7 data-first clear");
        // R7: address first with gap
        pulse(4'b0100);
        axi_write(4'h4, 32'h8, 4'h1, 1, 4, 4'h0);
        axi_read(4'h0, 32'h4, "R7 address-first clear");

        // R5: request on line 3 in the commit cycle of a clear of lines 2 and 3
        pulse(4'b1000);
        axi_write(4'h4, 32'hC, 4'h1, 0, 0, 4'b1000);
        axi_read(4'h0, 32'h8, "R5 set wins over clear");
        chk(irq_req_o == 4'h8, "R5 irq_req_o after collision", 32'(irq_req_o), 8);

        // R4: clear everything
        axi_write(4'h4, 32'hFFFF_FFFF, 4'hF, 0, 0, 4'h0);
        axi_read(4'h0, 32'h0, "R4 clear all");
        chk(irq_req_o == 4'h0, "R4 irq_req_o cleared", 32'(irq_req_o), 0);

        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule